// File: doc/BRIEF.md
# SPI Serial EEPROM Target Model

This block is a synthesizable SPI target that behaves like a byte-wide serial EEPROM, with its storage held in an on-chip array. It watches chip select, the serial clock and the serial input, all oversampled by the system clock. It decodes one instruction byte per selection and answers on the serial output. The supported operations are write enable and disable, status read and write, sequential read, and page write.

The protocol always carries a 16-bit address, most significant byte first. Only the low `AW` bits select a byte: `AW = 16` gives the full 64 KiB, and the smaller default keeps elaboration light. A committed write or status write starts a busy window of `BUSY_CYC` system clocks. During that window the buffered page is copied into the array, the busy flag reads 1, and every instruction except the status read is dropped. Two mechanisms guard the data. Two protect bits lock an upper part of the array. An enable bit, together with a low level on the write-protect input, freezes the status register.

Top module: `spi_eeprom_model`

## Requirements
- R1: After reset the status byte reads 0x00, every array byte reads 0xFF, and SO is low at every clock while chip select is high.
- R2: Opcode 0x06 sets the write-enable flag and opcode 0x04 clears it. Opcode 0x05 returns the status byte repeatedly, laid out as bit0 busy, bit1 write-enable, bits 3:2 protect field, bit7 status-lock enable, with bits 6:4 zero.
- R3: A write (opcode 0x02, then address high byte, address low byte, then data) issued while the write-enable flag is clear changes no array byte.
- R4: A committed write clears the write-enable flag and holds the busy bit at 1 for BUSY_CYC clocks. While busy, a read (0x03) returns zeros and 0x06 and 0x04 are ignored; only 0x05 is answered.
- R5: Data bytes of one write go to consecutive addresses within a 128-byte page. After offset 127 the address wraps to offset 0 of the same page, and later bytes overwrite earlier ones.
- R6: A status write (opcode 0x01 and one data byte) is accepted only with the write-enable flag set. It loads the protect field from data bits 3:2 and the lock enable from bit 7, clears the write-enable flag and starts a busy window.
- R7: With protect field 01 the top quarter of the array is read-only, with 10 the top half, with 11 the whole array, and with 00 nothing. Protected bytes of a write are dropped while unprotected ones are stored.
- R8: While the lock enable is 1 and wp_n is low, a status write changes nothing, including the write-enable flag. With wp_n high it is accepted.
- R9: A write or status write commits only if chip select rises after a whole number of bytes, with at least one data byte. Otherwise nothing is stored, no busy window starts and the write-enable flag keeps its value.
- R10: A read (opcode 0x03 and a 16-bit address) streams bytes from rising addresses, wrapping from the top of the array to 0. Address bits at and above AW are ignored.
- R11: Both SPI mode 0 (clock idle low) and mode 3 (clock idle high) work. SI is sampled on rising SCK and SO changes only after a falling SCK or on deselection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data into the target |
| wp_n | input | 1 | Write-protect input, active low, guards the status register |
| so | output | 1 | Serial data out, low when not selected |

## Verification
The assertions assume that cs_n, sck and si are synchronous to clk. They also assume that each SCK level lasts several system clocks, so every serial edge is seen as exactly one rising or one falling step. A further assumption is that chip select moves only while SCK rests at its idle level. The stimulus drives every serial line on the falling system-clock edge and holds each SCK phase for four clocks. It opens and closes each selection at the idle level of the mode in use. It also polls or waits well past the busy window before any step whose outcome depends on busy having ended.

// File: rtl/spi_eeprom_model.sv
module spi_eeprom_model #(
  parameter int AW       = 11,
  parameter int BUSY_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wp_n,
  output logic so
);
  localparam int PW    = 7;
  localparam int PAGE  = 1 << PW;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(BUSY_CYC + 1);

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {PH_OP, PH_AH, PH_AL, PH_DAT, PH_IGN} ph_t;

  logic          sck_q, cs_q;
  logic [2:0]    bcnt;
  logic [6:0]    shin;
  ph_t           ph;
  logic [7:0]    op, sr_new;
  logic [15:0]   adr;
  logic          wel, wpen, got, wr_pend;
  logic [1:0]    bp;
  logic [CW-1:0] bcyc;
  logic [PW:0]   pidx;
  logic [AW-PW-1:0] wpage;
  logic [PAGE-1:0]  pval;
  logic [7:0]    pbuf [PAGE];
  logic [7:0]    mem  [DEPTH];

  wire       rise   = ~cs_n & sck & ~sck_q;
  wire       fall   = ~cs_n & ~sck & sck_q;
  wire       done   = rise && bcnt == 3'd7;
  wire [7:0] rxb    = {shin, si};
  wire       wip    = bcyc != '0;
  wire [7:0] status = {wpen, 3'b000, bp, wel, wip};
  wire       cs_up  = cs_n & ~cs_q;
  wire [AW-1:0] a     = adr[AW-1:0];
  wire [AW-1:0] waddr = {wpage, pidx[PW-1:0]};
  wire       commit = cs_up && ph == PH_DAT && got && bcnt == 3'd0;
  wire       sr_locked = wpen && !wp_n;

  function automatic logic prot(input logic [AW-1:0] x, input logic [1:0] f);
    case (f)
      2'b00:   prot = 1'b0;
      2'b01:   prot = &x[AW-1:AW-2];
      2'b10:   prot = x[AW-1];
      default: prot = 1'b1;
    endcase
  endfunction

  wire mem_we = wr_pend && wip && !pidx[PW] && pval[pidx[PW-1:0]] && !prot(waddr, bp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; bcnt <= '0; shin <= '0; ph <= PH_OP;
      op <= '0; sr_new <= '0; adr <= '0; wel <= 1'b0; wpen <= 1'b0; bp <= '0;
      got <= 1'b0; wr_pend <= 1'b0; bcyc <= '0; pidx <= '0; wpage <= '0; pval <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        bcnt <= '0; ph <= PH_OP; got <= 1'b0;
      end else if (rise) begin
        bcnt <= bcnt + 3'd1;
        shin <= {shin[5:0], si};
      end
      if (done) begin
        case (ph)
          PH_OP: begin
            op <= rxb;
            ph <= PH_IGN;
            if (rxb == OP_RDSR) ph <= PH_DAT;
            else if (!wip) begin
              case (rxb)
                OP_READ:  ph <= PH_AH;
                OP_WRITE: if (wel) begin ph <= PH_AH; pval <= '0; end
                OP_WRSR:  if (wel) ph <= PH_DAT;
                OP_WREN:  wel <= 1'b1;
                OP_WRDI:  wel <= 1'b0;
                default:  ;
              endcase
            end
          end
          PH_AH: begin adr[15:8] <= rxb; ph <= PH_AL; end
          PH_AL: begin adr[7:0]  <= rxb; ph <= PH_DAT; end
          PH_DAT: begin
            if (op == OP_WRITE) begin
              pval[adr[PW-1:0]] <= 1'b1;
              adr[PW-1:0] <= adr[PW-1:0] + 7'd1;
              got <= 1'b1;
            end else if (op == OP_READ) begin
              adr <= adr + 16'd1;
            end else if (op == OP_WRSR) begin
              sr_new <= rxb;
              got <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (wip) begin
        bcyc <= bcyc - 1'b1;
        if (!pidx[PW]) pidx <= pidx + 1'b1;
      end
      if (commit && op == OP_WRITE) begin
        wel <= 1'b0; bcyc <= CW'(BUSY_CYC); wr_pend <= 1'b1;
        wpage <= a[AW-1:PW]; pidx <= '0;
      end
      if (commit && op == OP_WRSR && !sr_locked) begin
        bp <= sr_new[3:2]; wpen <= sr_new[7]; wel <= 1'b0;
        bcyc <= CW'(BUSY_CYC); wr_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk)
    if (done && ph == PH_DAT && op == OP_WRITE) pbuf[adr[PW-1:0]] <= rxb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (mem_we) begin
      mem[waddr] <= pbuf[pidx[PW-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     so <= 1'b0;
    else if (cs_n)  so <= 1'b0;
    else if (fall) begin
      if (ph == PH_DAT && op == OP_READ)      so <= mem[a][~bcnt];
      else if (ph == PH_DAT && op == OP_RDSR) so <= status[~bcnt];
      else                                    so <= 1'b0;
    end
  end

  a_r1_so_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !so);
  a_r4_busy_holds_wel_low: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> !wel);
  a_r4_busy_freezes_status: assert property (@(posedge clk) disable iff (!rst_n)
    wip |=> $stable({wpen, bp}));
  a_r3_busy_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel) && !wel);
  a_r9_commit_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(bcnt) == 3'd0 && $past(cs_n));
  a_r5_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ph == PH_DAT && op == OP_WRITE) |=> $stable(adr[15:PW]));
  a_r8_lock_blocks_status: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({wpen, bp}) |-> !$past(sr_locked));
  a_r11_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so) |-> $past(fall) || $past(cs_n));
endmodule

// File: tb/spi_eeprom_model_tb.sv
module spi_eeprom_model_tb_top;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam int BUSY = 1000;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
  wire so;

  always #2.5 clk = ~clk;

  spi_eeprom_model #(.AW(AW), .BUSY_CYC(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n), .so(so));

  int checks = 0, fails = 0, cyc = 0;
  bit ended = 0;
  always @(posedge clk) cyc++;

  logic [7:0] mem_m [int];
  bit m_wel = 0, m_wpen = 0;
  bit [1:0] m_bp = 0;
  int t_busy = -100000;
  logic [7:0] q0 [$];

  function automatic bit m_wip();
    return (cyc - t_busy) < BUSY;
  endfunction
  function automatic logic [7:0] m_get(int x);
    return mem_m.exists(x) ? mem_m[x] : 8'hFF;
  endfunction
  function automatic bit m_prot(int x);
    case (m_bp)
      2'd0: return 0;
      2'd1: return x >= DEPTH * 3 / 4;
      2'd2: return x >= DEPTH / 2;
      default: return 1;
    endcase
  endfunction
  function automatic logic [7:0] m_sr();
    return {m_wpen, 3'b000, m_bp, m_wel, m_wip()};
  endfunction

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic cs_lo(bit m3);
    sck = m3; tick(HALF); cs_n = 1'b0; tick(HALF);
  endtask
  task automatic cs_hi(bit m3);
    if (!m3) begin sck = 1'b0; tick(HALF); end
    cs_n = 1'b1; tick(HALF);
  endtask
  task automatic xbit(bit b, output bit r);
    sck = 1'b0; si = b; tick(HALF);
    r = so;
    sck = 1'b1; tick(HALF);
  endtask
  task automatic xbyte(logic [7:0] tx, output logic [7:0] rx);
    bit b;
    for (int i = 7; i >= 0; i--) begin xbit(tx[i], b); rx[i] = b; end
  endtask
  task automatic wait_idle();
    tick(BUSY + 60);
  endtask

  task automatic simple(logic [7:0] opc, bit m3 = 0);
    logic [7:0] r;
    bit ok = !m_wip();
    cs_lo(m3); xbyte(opc, r); cs_hi(m3);
    if (ok && opc == 8'h06) m_wel = 1;
    if (ok && opc == 8'h04) m_wel = 0;
  endtask

  task automatic rdsr(string req, int n = 1, bit m3 = 0);
    logic [7:0] r;
    cs_lo(m3); xbyte(8'h05, r);
    for (int i = 0; i < n; i++) begin xbyte(8'h00, r); check(req, r, m_sr()); end
    cs_hi(m3);
  endtask

  task automatic wr(logic [15:0] ad, logic [7:0] d [$], bit m3 = 0);
    logic [7:0] r;
    bit ok = !m_wip() && m_wel;
    cs_lo(m3); xbyte(8'h02, r); xbyte(ad[15:8], r); xbyte(ad[7:0], r);
    foreach (d[i]) xbyte(d[i], r);
    cs_hi(m3);
    if (ok && d.size() > 0) begin
      foreach (d[i]) begin
        int x = ((int'(ad) & ~127) | ((int'(ad) + i) & 127)) & (DEPTH - 1);
        if (!m_prot(x)) mem_m[x] = d[i];
      end
      m_wel = 0; t_busy = cyc;
    end
  endtask

  task automatic wrsr(logic [7:0] v);
    logic [7:0] r;
    bit ok = !m_wip() && m_wel && !(m_wpen && !wp_n);
    cs_lo(0); xbyte(8'h01, r); xbyte(v, r); cs_hi(0);
    if (ok) begin m_bp = v[3:2]; m_wpen = v[7]; m_wel = 0; t_busy = cyc; end
  endtask

  task automatic rd(logic [15:0] ad, int n, string req, bit m3 = 0);
    logic [7:0] r;
    bit ok = !m_wip();
    cs_lo(m3); xbyte(8'h03, r); xbyte(ad[15:8], r); xbyte(ad[7:0], r);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, r);
      check(req, r, ok ? m_get((int'(ad) + i) & (DEPTH - 1)) : 8'h00);
    end
    cs_hi(m3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] r;
    bit b;
    tick(10); rst_n = 1'b1; tick(5);
    check("R1 so idle", {7'd0, so}, 8'h00);
    rdsr("R1 status");
    rd(16'h0040, 2, "R1 erased");
    check("R1 so after deselect", {7'd0, so}, 8'h00);

    simple(8'h06); rdsr("R2 wren");
    simple(8'h04); rdsr("R2 wrdi", 2);

    wr(16'h0100, '{8'h11, 8'h22, 8'h33});
    rd(16'h0100, 3, "R3 no wel");

    simple(8'h06);
    wr(16'h0100, '{8'hA1, 8'hB2, 8'hC3});
    rdsr("R4 busy status");
    rd(16'h0100, 1, "R4 read while busy");
    simple(8'h06);
    wait_idle();
    rdsr("R4 wren ignored while busy");
    rd(16'h0100, 3, "R4 data stored");

    simple(8'h06);
    wr(16'h027E, '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05});
    wait_idle();
    rd(16'h027E, 2, "R5 page tail");
    rd(16'h0200, 3, "R5 page wrap");
    rd(16'h0280, 1, "R5 next page untouched");

    simple(8'h06); wr(16'h07FF, '{8'h5A}); wait_idle();
    simple(8'h06); wr(16'h0000, '{8'hA5}); wait_idle();
    rd(16'hFFFF, 3, "R10 top wrap");
    rd(16'hF900, 2, "R10 alias");

    wrsr(8'h04); rdsr("R6 no wel");
    simple(8'h06); wrsr(8'h04); rdsr("R6 busy after status write");
    wait_idle(); rdsr("R6 status loaded");

    simple(8'h06); wr(16'h0610, '{8'h77}); wait_idle();
    simple(8'h06); wr(16'h0410, '{8'h66}); wait_idle();
    rd(16'h0610, 1, "R7 quarter protected");
    rd(16'h0410, 1, "R7 quarter open");
    simple(8'h06); wrsr(8'h08); wait_idle();
    simple(8'h06); wr(16'h0420, '{8'h55}); wait_idle();
    simple(8'h06); wr(16'h0320, '{8'h44}); wait_idle();
    rd(16'h0420, 1, "R7 half protected");
    rd(16'h0320, 1, "R7 half open");
    simple(8'h06); wrsr(8'h0C); wait_idle();
    simple(8'h06); wr(16'h0030, '{8'h33}); wait_idle();
    rd(16'h0030, 1, "R7 all protected");

    simple(8'h06); wrsr(8'h8C); wait_idle();
    rdsr("R8 lock set");
    wp_n = 1'b0;
    simple(8'h06); wrsr(8'h00);
    rdsr("R8 status locked");
    wp_n = 1'b1;
    wrsr(8'h00); wait_idle();
    rdsr("R8 unlocked write");

    simple(8'h06);
    cs_lo(0); xbyte(8'h02, r); xbyte(8'h05, r); xbyte(8'h00, r); xbyte(8'h99, r);
    xbit(1'b1, b); xbit(1'b0, b); xbit(1'b1, b);
    cs_hi(0);
    rdsr("R9 partial byte");
    rd(16'h0500, 1, "R9 nothing stored");
    wr(16'h0500, q0);
    rdsr("R9 no data byte");
    simple(8'h04);

    simple(8'h06, 1);
    wr(16'h0123, '{8'h9C, 8'h3E}, 1);
    rdsr("R11 mode3 busy", 1, 1);
    wait_idle();
    rd(16'h0123, 2, "R11 mode3 read", 1);
    rd(16'h0123, 2, "R11 mode0 read", 0);
    rdsr("R11 mode3 status", 2, 1);

    summary();
  end
endmodule